// File: doc/BRIEF.md
# Self-Clearing Test Cell Injector

This block sits in the transmit byte stream of a serial link and, on a software command, inserts one diagnostic cell between the normal cells. Software writes the launch bit. The bit reads back as set while the test cell is pending or in flight. The hardware clears the bit after the last byte of that cell has left the block, so software polls the bit to learn that the cell is gone.

The injected unit is 54 bytes long. Byte 0 is a PHY address taken from its own configuration input. Bytes 1 to 4 are the four programmed header pattern bytes. Bytes 5 to 53 all carry a fixed fill value. Normal traffic enters on a valid/ready byte stream and leaves on another, with a last marker on the final byte of each cell. The injection waits for a cell boundary, so a normal cell that has started always completes first. While the test cell is selected, the upstream ready is held low.

Both streams follow the usual rules. A byte moves when valid and ready are both high at a clock edge. The downstream side may drop ready at any time. An injected byte then stays on the output unchanged until it is accepted. When no injection is selected, upstream ready follows downstream ready combinationally. The configuration inputs must hold steady while the launch bit is set.

Top module: `loopcell_injector`

## Requirements
- R1: After reset, launch_busy is 0 and the block is a transparent pass-through: s_ready equals m_ready.
- R2: A launch_req pulse while launch_busy is 0 sets launch_busy at the next edge. Exactly one 54-byte unit is then emitted on the m_ stream.
- R3: Injected byte 0 equals phy_addr. Bytes 1 to 4 equal hdr_pattern[31:24], [23:16], [15:8] and [7:0], in that order.
- R4: Injected bytes 5 to 53 all equal 0x6A. m_last is 1 on byte 53 only.
- R5: launch_busy stays 1 up to and including the cycle of the final injected byte handshake. It reads 0 in the cycle that follows.
- R6: A launch_req while launch_busy is 1 is ignored and queues no second unit.
- R7: Injection starts only at a cell boundary. A normal cell already in progress completes first, and s_ready is 0 for as long as the injection is selected.
- R8: With launch_busy at 0, normal bytes pass from s_ to m_ unchanged and in order, with their last marker.
- R9: While m_ready is 0 during an injection, m_valid stays 1 and m_data and m_last hold their values.
- R10: A launch_req that falls in the same cycle as the final injected byte handshake is ignored. launch_busy still clears, and no further unit follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_req | input | 1 | Software write that sets the launch bit |
| launch_busy | output | 1 | Launch bit readback; clears by itself once the cell has left |
| phy_addr | input | 8 | PHY address placed in byte 0 of the test unit |
| hdr_pattern | input | 32 | Four header pattern bytes, most significant byte sent first |
| s_valid | input | 1 | Upstream byte valid |
| s_ready | output | 1 | Upstream byte ready |
| s_data | input | 8 | Upstream byte |
| s_last | input | 1 | Upstream last byte of a cell |
| m_valid | output | 1 | Downstream byte valid |
| m_ready | input | 1 | Downstream byte ready |
| m_data | output | 8 | Downstream byte |
| m_last | output | 1 | Downstream last byte of a cell |

## Verification
Two events can fall in the same cycle: the completion clear of the launch bit and a new software launch write. The bench raises launch_req exactly in the cycle of the final injected byte handshake. It then checks that launch_busy reads 0 in the next cycle and that the scoreboard sees no further bytes. A second collision is a launch arriving while a normal cell is half sent. The scoreboard is loaded with that cell, then the test cell, then the following normal cell. Any reordering is reported against the boundary requirement.

// File: rtl/loopcell_pkg.sv
package loopcell_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/loopcell_launch_reg.sv
module loopcell_launch_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_req,
  input  logic unit_done,
  output logic busy
);
  logic busy_q;

  // completion wins; a request while set is dropped
  always_ff @(posedge clk) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (unit_done)  busy_q <= 1'b0;
    else if (launch_req) busy_q <= 1'b1;
  end

  assign busy = busy_q;
endmodule

// File: rtl/loopcell_unit_builder.sv
module loopcell_unit_builder
  import loopcell_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned HDR_BYTES  = 4,
  parameter logic [7:0]  FILL_BYTE  = 8'h6A
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance,
  input  byte_t                   phy_addr,
  input  logic [HDR_BYTES*8-1:0]  hdr_pattern,
  output byte_t                   unit_data,
  output logic                    unit_last
);
  localparam int unsigned UNIT_BYTES = CELL_BYTES + 1;
  localparam int unsigned IDX_W      = $clog2(UNIT_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(UNIT_BYTES - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     idx_q <= '0;
    else if (advance && unit_last)  idx_q <= '0;
    else if (advance)               idx_q <= idx_q + 1'b1;
  end

  assign unit_last = (idx_q == LAST_IDX);

  always_comb begin
    unit_data = FILL_BYTE;
    if (idx_q == '0) unit_data = phy_addr;
    for (int k = 0; k < int'(HDR_BYTES); k++) begin
      if (idx_q == IDX_W'(k + 1))
        unit_data = hdr_pattern[(int'(HDR_BYTES) - 1 - k)*8 +: 8];
    end
  end
endmodule

// File: rtl/loopcell_tx_arbiter.sv
module loopcell_tx_arbiter
  import loopcell_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  busy,
  input  logic  s_valid,
  output logic  s_ready,
  input  byte_t s_data,
  input  logic  s_last,
  output logic  m_valid,
  input  logic  m_ready,
  output byte_t m_data,
  output logic  m_last,
  input  byte_t unit_data,
  input  logic  unit_last,
  output logic  unit_adv,
  output logic  unit_done,
  output logic  sel_inj,
  output logic  inj_q
);
  logic in_cell_q;

  // a pending launch takes the link only between normal cells
  assign sel_inj   = inj_q | (busy & ~in_cell_q);
  assign unit_adv  = sel_inj & m_ready;
  assign unit_done = unit_adv & unit_last;

  always_comb begin
    if (sel_inj) begin
      m_valid = 1'b1;
      m_data  = unit_data;
      m_last  = unit_last;
      s_ready = 1'b0;
    end else begin
      m_valid = s_valid;
      m_data  = s_data;
      m_last  = s_last;
      s_ready = m_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_q     <= 1'b0;
      in_cell_q <= 1'b0;
    end else begin
      inj_q <= sel_inj & ~unit_done;
      if (!sel_inj && s_valid && m_ready) in_cell_q <= ~s_last;
    end
  end
endmodule

// File: rtl/loopcell_injector.sv
module loopcell_injector
  import loopcell_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned HDR_BYTES  = 4,
  parameter logic [7:0]  FILL_BYTE  = 8'h6A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch_req,
  output logic                   launch_busy,
  input  logic [7:0]             phy_addr,
  input  logic [HDR_BYTES*8-1:0] hdr_pattern,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [7:0]             s_data,
  input  logic                   s_last,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [7:0]             m_data,
  output logic                   m_last
);
  byte_t unit_data;
  logic  unit_last, unit_adv, unit_done, sel_inj, inj_q;

  loopcell_launch_reg u_launch (
    .clk(clk), .rst_n(rst_n), .launch_req(launch_req),
    .unit_done(unit_done), .busy(launch_busy)
  );

  loopcell_unit_builder #(
    .CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES), .FILL_BYTE(FILL_BYTE)
  ) u_builder (
    .clk(clk), .rst_n(rst_n), .advance(unit_adv),
    .phy_addr(phy_addr), .hdr_pattern(hdr_pattern),
    .unit_data(unit_data), .unit_last(unit_last)
  );

  loopcell_tx_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .busy(launch_busy),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .unit_data(unit_data), .unit_last(unit_last), .unit_adv(unit_adv),
    .unit_done(unit_done), .sel_inj(sel_inj), .inj_q(inj_q)
  );
endmodule

// File: rtl/loopcell_injector_chk.sv
module loopcell_injector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       launch_req,
  input logic       launch_busy,
  input logic [7:0] phy_addr,
  input logic       s_valid,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       sel_inj,
  input logic       inj_q
);
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(launch_busy) |-> $past(launch_req));

  assert_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_inj && !inj_q) |-> (m_valid && m_data == phy_addr));

  assert_clear_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(launch_busy) |-> $past(sel_inj && m_ready && m_last));

  assert_upstream_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_inj |-> !s_ready);

  assert_no_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_inj && s_valid && s_ready && !m_last) |=> !sel_inj);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_inj && !m_ready) |=> (sel_inj && m_valid && $stable(m_data) && $stable(m_last)));

  assert_collide_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_req && sel_inj && m_ready && m_last) |=> !launch_busy);
endmodule

bind loopcell_injector loopcell_injector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch_req(launch_req), .launch_busy(launch_busy),
  .phy_addr(phy_addr), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .sel_inj(sel_inj), .inj_q(inj_q)
);

// File: tb/loopcell_injector_bench.sv
`timescale 1ns/1ps
module loopcell_injector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_req = 1'b0;
  logic launch_busy;
  logic [7:0] phy_addr = 8'h17;
  logic [31:0] hdr_pattern = 32'hA1B2C3D4;
  logic s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0] s_data = 8'h00;
  logic m_valid, m_last;
  logic m_ready = 1'b1;
  logic [7:0] m_data;

  int total = 0;
  int bad = 0;
  bit clear_due = 1'b0;
  bit stall_on = 1'b0;
  logic [9:0] expq[$];   // {injected, last, data}

  always #2.5 clk = ~clk;

  loopcell_injector u_loopcell_injector (
    .clk(clk), .rst_n(rst_n), .launch_req(launch_req), .launch_busy(launch_busy),
    .phy_addr(phy_addr), .hdr_pattern(hdr_pattern),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_normal(input logic [7:0] base, input int len);
    for (int i = 0; i < len; i++) expq.push_back({1'b0, i == len - 1, base + 8'(i)});
  endtask

  task automatic push_unit(input logic [7:0] pa, input logic [31:0] hp);
    for (int i = 0; i < 54; i++) begin
      logic [7:0] b;
      if (i == 0) b = pa;
      else if (i <= 4) b = hp[(4 - i)*8 +: 8];
      else b = 8'h6A;
      expq.push_back({1'b1, i == 53, b});
    end
  endtask

  task automatic send_cell(input logic [7:0] base, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = base + 8'(i); s_last = (i == len - 1);
      forever begin
        #1;
        if (s_ready) break;
        @(negedge clk);
      end
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic pulse_launch();
    @(negedge clk); launch_req = 1'b1;
    @(negedge clk); launch_req = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (clear_due) begin
          check(launch_busy == 1'b0, "R5 busy clear after last", launch_busy, 0);
          clear_due = 1'b0;
        end
        if (m_valid && m_ready) begin
          if (expq.size() == 0) begin
            check(1'b0, "R6 unexpected byte", {m_last, m_data}, 0);
          end else begin
            logic [9:0] e;
            e = expq.pop_front();
            check({m_last, m_data} == e[8:0], e[9] ? "R3/R4 unit byte" : "R8 pass byte",
                  {m_last, m_data}, e[8:0]);
            if (e[9]) begin
              check(launch_busy == 1'b1, "R5 busy held", launch_busy, 1);
              if (s_valid) check(s_ready == 1'b0, "R7 upstream held", s_ready, 0);
              if (e[8]) clear_due = 1'b1;
            end
          end
        end
      end
    end
  end

  // back-pressure generator
  initial begin
    logic [7:0] lf = 8'h5B;
    forever begin
      @(negedge clk);
      if (stall_on) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        m_ready = lf[0];
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(launch_busy == 1'b0, "R1 reset busy", launch_busy, 0);
    check(s_ready == 1'b1, "R1 ready follows", s_ready, 1);
    m_ready = 1'b0; #1;
    check(s_ready == 1'b0, "R1 ready follows low", s_ready, 0);
    @(negedge clk); m_ready = 1'b1; rst_n = 1'b1;

    // R8 pass-through
    push_normal(8'h30, 6);
    send_cell(8'h30, 6); go_idle();
    drain();

    // R2 R3 R4 R5 idle launch
    push_unit(8'h17, 32'hA1B2C3D4);
    pulse_launch();
    #1; check(launch_busy == 1'b1, "R2 busy set", launch_busy, 1);
    drain();
    check(launch_busy == 1'b0, "R2 single unit busy low", launch_busy, 0);

    // R7 launch mid-cell
    push_normal(8'h40, 8);
    push_unit(8'h17, 32'hA1B2C3D4);
    push_normal(8'h80, 5);
    fork
      begin send_cell(8'h40, 8); send_cell(8'h80, 5); go_idle(); end
      begin repeat (2) @(negedge clk); pulse_launch(); end
    join
    drain();

    // R6 re-launch while busy
    push_unit(8'h17, 32'hA1B2C3D4);
    pulse_launch();
    repeat (10) @(negedge clk);
    pulse_launch();
    drain();
    repeat (70) @(negedge clk);
    check(expq.size() == 0 && launch_busy == 1'b0, "R6 no second unit", launch_busy, 0);

    // R9 back-pressure with new configuration
    phy_addr = 8'h05; hdr_pattern = 32'h0F0E0D0C;
    push_unit(8'h05, 32'h0F0E0D0C);
    stall_on = 1'b1;
    pulse_launch();
    drain();
    stall_on = 1'b0;
    @(negedge clk); m_ready = 1'b1;

    // R10 launch in final handshake cycle
    push_unit(8'h05, 32'h0F0E0D0C);
    pulse_launch();
    repeat (52) @(negedge clk);
    pulse_launch();
    #1; check(launch_busy == 1'b0, "R10 busy cleared on collision", launch_busy, 0);
    repeat (80) @(negedge clk);
    check(expq.size() == 0 && launch_busy == 1'b0, "R10 no extra unit", launch_busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule